// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block is the serial output stage of an audio converter whose bit clock and frame clock come from outside. It runs entirely in the master-clock domain. Both external clocks pass through a short synchronizer, and the bit-clock falling edges are detected there. A new 24-bit left/right sample pair is taken from a parallel interface at the start of every frame. The block then drives one data line, MSB first, so that a receiver can capture each bit on the rising bit-clock edge.

Two three-level mode inputs, each carried as a 2-bit code, set the framing and the word length.

- The framing is I2S-style (MSB one bit late), left-justified or right-justified.
- The word length is 16, 20 or 24 bits. For shorter words, the top bits of each 24-bit sample are sent.

For right-justified framing, the block counts the bit clocks in each half-frame and uses the previous half's count to place the LSB on the last bit clock.

Top module: `audtx_serial_out`

## Requirements
- R1: The framing code selects the format: 00 means right-justified, 01 means left-justified, and 10 means I2S-style.
- R2: The length code selects the word length W: 00 means 16, 01 means 20, and 10 means 24. The bits sent are sample[23] down to sample[24-W], MSB first.
- R3: The data line changes only after a bit-clock falling edge. It holds its value across the following rising edge.
- R4: In I2S-style framing, the left word is sent while the frame clock is low. Slot 0 is the bit period that begins at the falling bit-clock edge where the frame clock changes. Slot 0 is driven zero, and the MSB is sent in slot 1.
- R5: In left-justified framing, the left word is sent while the frame clock is high, with its MSB in slot 0.
- R6: In right-justified framing, the left word is sent while the frame clock is high. If the previous half-frame had P slots and P is at least W, the MSB is sent in slot P-W, so that the LSB falls in the last slot when the halves are equal.
- R7: In right-justified framing, if the previous half-frame was shorter than W slots, the word starts in slot 0.
- R8: Every slot outside the word is driven zero.
- R9: The sample pair is captured at the frame-clock edge that opens the left half. Changes on the sample inputs during a frame do not affect that frame.
- R10: During reset, and after it until the first bit-clock falling edge, the data line is low.
- R11: Code 11 on either mode input is treated as the middle level: I2S-style framing, or 24-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_code | input | 2 | Framing select code (three-level) |
| len_code | input | 2 | Word length select code (three-level) |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame clock |
| left_smp | input | 24 | Left channel sample |
| right_smp | input | 24 | Right channel sample |
| sdata | output | 1 | Serial data out |

## Verification
The hardest case to reach is the right-justified start after reset. Here the previous half-frame length is either unknown or shorter than the word. It must be reached without any bit clocks that the bench does not control. Each scenario therefore resets the block and drives a preamble of bit clocks. The preamble has a short left-level run, then a right-level half of a chosen length, before the checked frames begin. A deliberately short preamble half (4 slots) makes the first checked left word start at slot 0, and the next half moves it to the measured position. Each scenario also changes the sample inputs in the middle of the first frame, which shows that the pair captured at the frame edge is the one sent.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    localparam int LEN_W = 5;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_I2S = 2'd2
    } fmt_e;

    // low -> right-justified, high -> left-justified, middle (1x) -> I2S
    function automatic fmt_e decode_fmt(input logic [1:0] code);
        case (code)
            2'b00:   return FMT_RJ;
            2'b01:   return FMT_LJ;
            default: return FMT_I2S;
        endcase
    endfunction

    // low -> 16, high -> 20, middle (1x) -> 24
    function automatic logic [LEN_W-1:0] decode_len(input logic [1:0] code);
        case (code)
            2'b00:   return LEN_W'(16);
            2'b01:   return LEN_W'(20);
            default: return LEN_W'(24);
        endcase
    endfunction

endpackage

// File: rtl/audtx_sync.sv
module audtx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= '0;
            else     chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/audtx_mode_dec.sv
module audtx_mode_dec
    import audtx_pkg::*;
(
    input  logic [1:0]       fmt_code,
    input  logic [1:0]       len_code,
    output fmt_e             fmt,
    output logic [LEN_W-1:0] wlen
);
    always_comb begin
        fmt  = decode_fmt(fmt_code);
        wlen = decode_len(len_code);
    end
endmodule

// File: rtl/audtx_frame_track.sv
module audtx_frame_track
    import audtx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall,
    input  logic                lr,
    input  fmt_e                fmt,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    output logic [CNT_W-1:0]    slot,
    output logic [CNT_W-1:0]    half_len,
    output logic                chan_left,
    output logic [SAMPLE_W-1:0] word_l,
    output logic [SAMPLE_W-1:0] word_r
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
    } pair_t;

    localparam logic [CNT_W-1:0] SLOT_MAX = {CNT_W{1'b1}};

    pair_t pair_q;
    logic  lr_seen;
    logic  edge_hit;
    logic  to_left;

    always_comb begin
        edge_hit = fall && (lr != lr_seen);
        to_left  = (fmt == FMT_I2S) ? ~lr : lr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_seen   <= 1'b0;
            chan_left <= 1'b0;
            slot      <= '0;
            half_len  <= '0;
            pair_q    <= '0;
        end else if (fall) begin
            lr_seen   <= lr;
            chan_left <= to_left;
            if (edge_hit) begin
                slot     <= '0;
                half_len <= (slot == SLOT_MAX) ? slot : slot + 1'b1;
                if (to_left) begin
                    pair_q.l <= left_smp;
                    pair_q.r <= right_smp;
                end
            end else if (slot != SLOT_MAX) begin
                slot <= slot + 1'b1;
            end
        end
    end

    assign word_l = pair_q.l;
    assign word_r = pair_q.r;

    AST_SLOT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(slot));  // R3
    AST_LEN_HELD_IN_HALF: assert property (@(posedge clk) disable iff (rst)
        !edge_hit |=> $stable(half_len));  // R6
    AST_PAIR_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(edge_hit && to_left) |=> $stable(pair_q));  // R9
endmodule

// File: rtl/audtx_slot_mux.sv
module audtx_slot_mux
    import audtx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 8
) (
    input  fmt_e                fmt,
    input  logic [LEN_W-1:0]    wlen,
    input  logic [CNT_W-1:0]    slot,
    input  logic [CNT_W-1:0]    half_len,
    input  logic [SAMPLE_W-1:0] word,
    output logic                bit_o
);
    logic [CNT_W-1:0]    wl;
    logic [CNT_W-1:0]    start;
    logic [CNT_W-1:0]    k;
    logic [SAMPLE_W-1:0] sh;

    always_comb begin
        wl = CNT_W'(wlen);
        case (fmt)
            FMT_RJ:  start = (half_len >= wl) ? half_len - wl : '0;
            FMT_LJ:  start = '0;
            default: start = CNT_W'(1);
        endcase
        k     = slot - start;
        sh    = word << k;
        bit_o = (slot >= start) && (k < wl) && sh[SAMPLE_W-1];
    end
endmodule

// File: rtl/audtx_serial_out.sv
module audtx_serial_out
    import audtx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          fmt_code,
    input  logic [1:0]          len_code,
    input  logic                bclk,
    input  logic                lrclk,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    output logic                sdata
);
    logic [1:0]          sync_q;
    logic                bclk_d;
    logic                fall;
    logic                fall_q;
    fmt_e                fmt;
    logic [LEN_W-1:0]    wlen;
    logic [CNT_W-1:0]    slot;
    logic [CNT_W-1:0]    half_len;
    logic                chan_left;
    logic [SAMPLE_W-1:0] word_l;
    logic [SAMPLE_W-1:0] word_r;
    logic [SAMPLE_W-1:0] word_sel;
    logic                next_bit;

    audtx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({lrclk, bclk}),
        .q   (sync_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            bclk_d <= sync_q[0];
            fall_q <= fall;
        end
    end

    assign fall = bclk_d & ~sync_q[0];

    audtx_mode_dec u_mode (
        .fmt_code (fmt_code),
        .len_code (len_code),
        .fmt      (fmt),
        .wlen     (wlen)
    );

    audtx_frame_track #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .fall      (fall),
        .lr        (sync_q[1]),
        .fmt       (fmt),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .slot      (slot),
        .half_len  (half_len),
        .chan_left (chan_left),
        .word_l    (word_l),
        .word_r    (word_r)
    );

    assign word_sel = chan_left ? word_l : word_r;

    audtx_slot_mux #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_mux (
        .fmt      (fmt),
        .wlen     (wlen),
        .slot     (slot),
        .half_len (half_len),
        .word     (word_sel),
        .bit_o    (next_bit)
    );

    always_ff @(posedge clk) begin
        if (rst)         sdata <= 1'b0;
        else if (fall_q) sdata <= next_bit;
    end

    AST_DATA_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !fall_q |=> $stable(sdata));  // R3
    AST_I2S_LEAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fall_q && slot == '0 && fmt == FMT_I2S) |=> !sdata);  // R4
endmodule

// File: tb/audtx_serial_out_test.sv
module audtx_serial_out_test;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_code = 2'b00;
    logic [1:0]  len_code = 2'b00;
    logic        bclk = 1'b1;
    logic        lrclk = 1'b0;
    logic [23:0] left_smp = '0;
    logic [23:0] right_smp = '0;
    logic        sdata;

    int checks = 0;
    int errors = 0;

    audtx_serial_out uut (
        .clk       (clk),
        .rst       (rst),
        .fmt_code  (fmt_code),
        .len_code  (len_code),
        .bclk      (bclk),
        .lrclk     (lrclk),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .sdata     (sdata)
    );

    always #10 clk = ~clk;

    task automatic check(input logic got, input logic exp, input string tag, input int s);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s slot %0d: got %b expected %b", tag, s, got, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [1:0] fc, input logic [1:0] lc,
                                     input int s, input int prev, input logic [23:0] w);
        int wl;
        int st;
        int k;
        logic [23:0] t;
        wl = (lc == 2'b00) ? 16 : (lc == 2'b01) ? 20 : 24;
        if (fc == 2'b00)      st = (prev >= wl) ? prev - wl : 0;
        else if (fc == 2'b01) st = 0;
        else                  st = 1;
        k = s - st;
        if (s < st || k >= wl) return 1'b0;
        t = w << k;
        return t[23];
    endfunction

    // one bit period: falling edge with frame level, optional checks before
    // the rising edge and again just before the next falling edge
    task automatic bit_slot(input logic lr_val, input logic do_chk, input logic exp,
                            input string tag, input int s);
        @(negedge clk);
        bclk  = 1'b0;
        lrclk = lr_val;
        repeat (HALF - 1) @(negedge clk);
        if (do_chk) check(sdata, exp, tag, s);
        @(negedge clk);
        bclk = 1'b1;
        repeat (HALF - 1) @(negedge clk);
        if (do_chk) check(sdata, exp, "R3 hold across rising edge", s);
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        bclk  = 1'b1;
        lrclk = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        check(sdata, 1'b0, "R10 idle after reset", -1);
    endtask

    task automatic run_scenario(input logic [1:0] fc, input logic [1:0] lc, input int n,
                                input int pre_len, input logic [23:0] al, input logic [23:0] ar,
                                input logic [23:0] bl, input logic [23:0] br, input string tag);
        logic lvl_left;
        int   prev;
        logic [23:0] wl_word;
        logic [23:0] wr_word;
        do_reset();
        fmt_code  = fc;
        len_code  = lc;
        left_smp  = al;
        right_smp = ar;
        lvl_left  = fc[1] ? 1'b0 : 1'b1;
        for (int i = 0; i < 2; i++) bit_slot(lvl_left, 1'b0, 1'b0, tag, i);
        for (int i = 0; i < pre_len; i++) bit_slot(~lvl_left, 1'b0, 1'b0, tag, i);
        prev = pre_len;
        for (int fr = 0; fr < 2; fr++) begin
            wl_word = (fr == 0) ? al : bl;
            wr_word = (fr == 0) ? ar : br;
            for (int s = 0; s < n; s++) begin
                if (fr == 0 && s == 5) begin
                    left_smp  = bl;   // R9: mid-frame change must wait for next frame
                    right_smp = br;
                end
                bit_slot(lvl_left, 1'b1, exp_bit(fc, lc, s, prev, wl_word),
                         {tag, " R8 R9 left"}, s);
            end
            prev = n;
            for (int s = 0; s < n; s++)
                bit_slot(~lvl_left, 1'b1, exp_bit(fc, lc, s, prev, wr_word),
                         {tag, " R8 R9 right"}, s);
            prev = n;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sdata, 1'b0, "R10 during reset", -1);
        run_scenario(2'b10, 2'b10, 32, 32, 24'hA5C3F1, 24'h3C0F96, 24'h81_7E_55, 24'hF0_0F_AA,
                     "R1 R4 R2 i2s24");
        run_scenario(2'b01, 2'b00, 32, 32, 24'hFFFF00, 24'h8001FF, 24'h1234AB, 24'hC0FFEE,
                     "R1 R5 R2 lj16");
        run_scenario(2'b00, 2'b01, 32, 32, 24'h9ABCDE, 24'h6B5A30, 24'hFFFFFF, 24'h800010,
                     "R1 R6 R2 rj20");
        run_scenario(2'b00, 2'b10, 28, 28, 24'hD00D01, 24'h400003, 24'h7FFFFF, 24'h000001,
                     "R6 rj24 short halves");
        run_scenario(2'b00, 2'b00, 32, 4, 24'hF00F0F, 24'hAAAA55, 24'h5555AA, 24'h0FF0F0,
                     "R7 rj16 short prior half");
        run_scenario(2'b11, 2'b11, 25, 25, 24'hB7E151, 24'h628AED, 24'h2A6D1F, 24'hC3A5E9,
                     "R11 code11 i2s24");
        run_scenario(2'b01, 2'b01, 20, 20, 24'hE1D2C3, 24'h1F2E3D, 24'h000FFF, 24'hFFF000,
                     "R5 lj20 exact fit");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule